// File: doc/BRIEF.md
# Shared-Memory Multi-Slice FIFO Controller

This block divides a single memory of 1024 words of 32 bits into 24 independent circular FIFO slices. Each of 12 serial channels owns two slices: a transmit slice at even index `2*c` and a receive slice at odd index `2*c+1`. Software places every slice anywhere in the memory by giving it a base address and a size in words. The controller keeps a write offset, a read offset and a fill count for each slice. It also keeps a programmable alarm level, two sticky error flags and an interrupt mask. Software must keep the slices from overlapping; the controller does not check this.

Data enters through a valid/ready push stream and leaves through a pop request stream. Both streams name the target slice by index. The memory has a single port, so a push and a pop cannot be served in the same cycle. A pop always wins: `pop_ready` is tied high, and `push_ready` falls in every cycle where `pop_valid` is high. A producer therefore has to hold its word until `push_ready` returns. An accepted pop of a non-empty slice returns the word one cycle later on `rd_valid`/`rd_data`. That output has no back-pressure. Two summary vectors report, per channel, whether either slice has an interrupt pending and whether either slice is asking for a DMA transfer.

Configuration goes through a plain register port: slice index, 3-bit field code, write strobe and write data, plus a combinational read-back. In the same cycle, a configuration write that resets, reloads or resizes a slice overrides push and pop pointer updates on that slice.

Top module: `sfc_fifo_ctrl`

## Requirements
- R1: After reset every slice is disabled, with base 0, size 0, count 0, alarm level 0 and mask 0. `irq_pend` and `dma_pend` are zero, and `push_ready` is 1 while `pop_valid` is 0.
- R2: A slice word lives at memory address (base + offset) mod 1024. Offsets wrap to 0 when they reach the slice size, and words leave each slice in the order they entered.
- R3: `pop_ready` is always 1. A pop accepted on an enabled, non-empty slice gives `rd_valid`=1 and the oldest word on `rd_data` one cycle later. A push accepted on an enabled slice with count < size stores the word and increments the count (field 5, COUNT).
- R4: A push accepted on an enabled slice whose count ≥ size is dropped, leaves the count unchanged, and sets overflow (interrupt-status bit 1).
- R5: A pop on an enabled, empty slice produces no `rd_valid`, leaves the count unchanged, and sets underflow (interrupt-status bit 2).
- R6: When `pop_valid` is high, `push_ready` is 0 and the pending push is not taken. When `pop_valid` is low, `push_ready` is 1.
- R7: A transmit slice (even index) is in alarm when count ≤ alarm level. A receive slice (odd index) is in alarm when count ≥ alarm level. Field 2 (STAT) reads {bit2 alarm, bit1 full, bit0 empty}. Field 1 sets the alarm level from bits 10:0.
- R8: Field 3 (ISTAT) reads {bit2 underflow, bit1 overflow, bit0 enabled-and-alarm}. Writing 1 to bit 1 or bit 2 clears that flag. The slice interrupt is the OR of ISTAT ANDed with the mask in field 4 (IMASK, bits 2:0).
- R9: `irq_pend[c]` is the OR of the interrupts of slices 2c and 2c+1. `dma_pend[c]` is high when either of those slices is enabled and in alarm.
- R10: Field 0 (CTRL): bit 0 is enable. Writing bit 1 as 1 clears both offsets and the count. On a disabled slice, pushes and pops change neither the count nor the flags.
- R11: Writing field 6 (PTR) loads the read offset from bits 9:0 and sets the count to (write offset − read offset) mod size. Reading field 6 gives the read offset in bits 9:0 and the write offset in bits 25:16.
- R12: Writing field 7 (SIZE) sets the base from bits 9:0 and the size from bits 26:16, and clears both offsets and the count. The field reads back in the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Push accepted this cycle |
| push_slice | input | 5 | Target slice of the push |
| push_data | input | 32 | Word to store |
| pop_valid | input | 1 | Pop request |
| pop_ready | output | 1 | Pop accepted (always 1) |
| pop_slice | input | 5 | Source slice of the pop |
| rd_valid | output | 1 | Popped word valid |
| rd_data | output | 32 | Popped word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slice | input | 5 | Slice addressed by configuration |
| cfg_field | input | 3 | Field code 0..7 |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the addressed field |
| irq_pend | output | 12 | Per-channel pending interrupt |
| dma_pend | output | 12 | Per-channel pending DMA request |

## Verification
The hardest case to reach is a slice whose storage crosses the top of the memory and whose read offset is then rewound. Reaching it needs a fill past the wrap, a partial drain and a refill first, so that old words still sit at the addresses being read again. The stimulus places one slice at base 1020 with size 8 and cycles it through full, overflow, partial drain, refill and empty. It then rewinds another slice with a PTR write so that already-popped words are replayed. A behavioural memory-and-queue model checks every returned word, along with the summary vectors and the cost of pop priority on `push_ready`.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    F_CTRL  = 3'd0,
    F_ALARM = 3'd1,
    F_STAT  = 3'd2,
    F_ISTAT = 3'd3,
    F_IMASK = 3'd4,
    F_COUNT = 3'd5,
    F_PTR   = 3'd6,
    F_SIZE  = 3'd7
  } field_e;

  localparam int SIZE_LSB = 16;
  localparam int WPTR_LSB = 16;
endpackage

// File: rtl/sfc_mem.sv
module sfc_mem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/sfc_slice.sv
module sfc_slice
  import sfc_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter bit IS_RX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  field_e        cfg_field,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          push_do,
  input  logic          pop_do,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full,
  output logic          empty,
  output logic          en_o,
  output logic          irq,
  output logic          dma_req
);
  localparam int SW = AW + 1;

  logic          en, ovf, udf;
  logic [AW-1:0] base;
  logic [SW-1:0] size, alm, wp, rp, cnt;
  logic [2:0]    mask;
  logic          alarm;
  logic [2:0]    istat;
  logic          push_ok, pop_ok, ptr_clr, ptr_load;
  logic [SW-1:0] new_rp, reload_cnt;

  function automatic logic [SW-1:0] bump(input logic [SW-1:0] p, input logic [SW-1:0] lim);
    return (p + SW'(1) == lim) ? '0 : p + SW'(1);
  endfunction

  assign full    = (cnt >= size);
  assign empty   = (cnt == '0);
  assign en_o    = en;
  assign alarm   = IS_RX ? (cnt >= alm) : (cnt <= alm);
  assign istat   = {udf, ovf, en & alarm};
  assign irq     = |(istat & mask);
  assign dma_req = en & alarm;
  assign wr_addr = base + wp[AW-1:0];
  assign rd_addr = base + rp[AW-1:0];

  assign push_ok  = push_do & en & ~full;
  assign pop_ok   = pop_do & en & ~empty;
  assign ptr_clr  = cfg_we & (((cfg_field == F_CTRL) & cfg_wdata[1]) | (cfg_field == F_SIZE));
  assign ptr_load = cfg_we & (cfg_field == F_PTR);
  assign new_rp   = {1'b0, cfg_wdata[AW-1:0]};
  assign reload_cnt = (wp >= new_rp) ? (wp - new_rp) : (wp + size - new_rp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ovf  <= 1'b0;
      udf  <= 1'b0;
      base <= '0;
      size <= '0;
      alm  <= '0;
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      mask <= '0;
    end else begin
      if (cfg_we) begin
        unique case (cfg_field)
          F_CTRL:  en   <= cfg_wdata[0];
          F_ALARM: alm  <= cfg_wdata[SW-1:0];
          F_IMASK: mask <= cfg_wdata[2:0];
          F_SIZE: begin
            base <= cfg_wdata[AW-1:0];
            size <= cfg_wdata[SIZE_LSB +: SW];
          end
          F_ISTAT: begin
            if (cfg_wdata[1]) ovf <= 1'b0;
            if (cfg_wdata[2]) udf <= 1'b0;
          end
          default: ;
        endcase
      end
      if (push_do && en && full)  ovf <= 1'b1;
      if (pop_do && en && empty)  udf <= 1'b1;
      if (ptr_clr) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else if (ptr_load) begin
        rp  <= new_rp;
        cnt <= reload_cnt;
      end else begin
        if (push_ok) wp <= bump(wp, size);
        if (pop_ok)  rp <= bump(rp, size);
        if (push_ok && !pop_ok)      cnt <= cnt + SW'(1);
        else if (pop_ok && !push_ok) cnt <= cnt - SW'(1);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_field)
      F_CTRL:  cfg_rdata = DW'(en);
      F_ALARM: cfg_rdata = DW'(alm);
      F_STAT:  cfg_rdata = DW'({alarm, full, empty});
      F_ISTAT: cfg_rdata = DW'(istat);
      F_IMASK: cfg_rdata = DW'(mask);
      F_COUNT: cfg_rdata = DW'(cnt);
      F_PTR:   cfg_rdata = (DW'(wp[AW-1:0]) << WPTR_LSB) | DW'(rp[AW-1:0]);
      F_SIZE:  cfg_rdata = (DW'(size) << SIZE_LSB) | DW'(base);
      default: cfg_rdata = '0;
    endcase
  end

  // R4: a push hitting a full enabled slice leaves the overflow flag set
  a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (push_do && en && full) |=> ovf);
  // R5: a pop of an empty enabled slice leaves the underflow flag set
  a_r5_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_do && en && empty) |=> udf);
  // R3: an accepted push grows the count by one
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push_do && en && !full && !pop_do && !cfg_we) |=> (cnt == $past(cnt) + SW'(1)));
  // R10: a disabled slice keeps its count without configuration writes
  a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_we) |=> $stable(cnt));
endmodule

// File: rtl/sfc_fifo_ctrl.sv
module sfc_fifo_ctrl
  import sfc_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int DEPTH = 1024,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  output logic                       push_ready,
  input  logic [$clog2(2*NCH)-1:0]   push_slice,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop_valid,
  output logic                       pop_ready,
  input  logic [$clog2(2*NCH)-1:0]   pop_slice,
  output logic                       rd_valid,
  output logic [DW-1:0]              rd_data,
  input  logic                       cfg_we,
  input  logic [$clog2(2*NCH)-1:0]   cfg_slice,
  input  logic [2:0]                 cfg_field,
  input  logic [DW-1:0]              cfg_wdata,
  output logic [DW-1:0]              cfg_rdata,
  output logic [NCH-1:0]             irq_pend,
  output logic [NCH-1:0]             dma_pend
);
  localparam int NSL = 2 * NCH;
  localparam int AW  = $clog2(DEPTH);

  logic [AW-1:0] s_waddr [NSL];
  logic [AW-1:0] s_raddr [NSL];
  logic [DW-1:0] s_rdata [NSL];
  logic [NSL-1:0] s_full, s_empty, s_en, s_irq, s_dma;
  logic push_fire, pop_fire, push_in, pop_in, cfg_in;
  logic mem_we, mem_re;
  field_e fld;

  assign fld        = field_e'(cfg_field);
  assign pop_ready  = 1'b1;
  assign push_ready = ~pop_valid;
  assign push_fire  = push_valid & push_ready;
  assign pop_fire   = pop_valid & pop_ready;
  assign push_in    = int'(push_slice) < NSL;
  assign pop_in     = int'(pop_slice) < NSL;
  assign cfg_in     = int'(cfg_slice) < NSL;

  for (genvar i = 0; i < NSL; i++) begin : g_slice
    sfc_slice #(.AW(AW), .DW(DW), .IS_RX(i % 2 == 1)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we && int'(cfg_slice) == i),
      .cfg_field (fld),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (s_rdata[i]),
      .push_do   (push_fire && int'(push_slice) == i),
      .pop_do    (pop_fire && int'(pop_slice) == i),
      .wr_addr   (s_waddr[i]),
      .rd_addr   (s_raddr[i]),
      .full      (s_full[i]),
      .empty     (s_empty[i]),
      .en_o      (s_en[i]),
      .irq       (s_irq[i]),
      .dma_req   (s_dma[i])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign irq_pend[c] = s_irq[2*c] | s_irq[2*c+1];
    assign dma_pend[c] = s_dma[2*c] | s_dma[2*c+1];
  end

  assign mem_we    = push_fire & push_in & s_en[push_slice] & ~s_full[push_slice];
  assign mem_re    = pop_fire & pop_in & s_en[pop_slice] & ~s_empty[pop_slice];
  assign cfg_rdata = cfg_in ? s_rdata[cfg_slice] : '0;

  sfc_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (s_waddr[push_slice]),
    .wdata (push_data),
    .re    (mem_re),
    .raddr (s_raddr[pop_slice]),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= mem_re;
  end

  // R6: the single memory port never sees a write and a read together
  a_r6_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R3: returned data always follows a pop request
  a_r3_rd_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(pop_valid));
endmodule

// File: tb/tb_sfc_fifo_ctrl.sv
module tb_sfc_fifo_ctrl;
  localparam int NCH = 12;
  localparam int NSL = 24;
  localparam int MD  = 1024;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, pop_valid = 0, cfg_we = 0;
  logic push_ready, pop_ready, rd_valid;
  logic [4:0] push_slice = 0, pop_slice = 0, cfg_slice = 0;
  logic [31:0] push_data = 0, cfg_wdata = 0, rd_data, cfg_rdata;
  logic [2:0] cfg_field = 0;
  logic [NCH-1:0] irq_pend, dma_pend;

  always #10 clk = ~clk;

  sfc_fifo_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_slice(push_slice), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_slice(pop_slice),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_slice(cfg_slice), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_pend(irq_pend), .dma_pend(dma_pend)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  int m_base[NSL], m_size[NSL], m_alm[NSL], m_wp[NSL], m_rp[NSL], m_cnt[NSL], m_mask[NSL];
  bit m_en[NSL], m_ovf[NSL], m_udf[NSL];
  logic [31:0] m_mem[MD];
  bit exp_rv = 0;
  logic [31:0] exp_rd = 0;

  function automatic bit m_alarm(int s);
    return (s % 2 == 1) ? (m_cnt[s] >= m_alm[s]) : (m_cnt[s] <= m_alm[s]);
  endfunction
  function automatic int m_istat(int s);
    return (int'(m_udf[s]) << 2) | (int'(m_ovf[s]) << 1) | int'(m_en[s] && m_alarm(s));
  endfunction
  function automatic logic [31:0] m_read(int s, int f);
    case (f)
      0: return 32'(m_en[s]);
      1: return 32'(m_alm[s]);
      2: return 32'((int'(m_alarm(s)) << 2) | (int'(m_cnt[s] >= m_size[s]) << 1) | int'(m_cnt[s] == 0));
      3: return 32'(m_istat(s));
      4: return 32'(m_mask[s]);
      5: return 32'(m_cnt[s]);
      6: return 32'(((m_wp[s] % 1024) << 16) | (m_rp[s] % 1024));
      default: return 32'((m_size[s] << 16) | m_base[s]);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSL; s++) begin
        m_base[s] = 0; m_size[s] = 0; m_alm[s] = 0; m_wp[s] = 0; m_rp[s] = 0;
        m_cnt[s] = 0; m_mask[s] = 0; m_en[s] = 0; m_ovf[s] = 0; m_udf[s] = 0;
      end
      exp_rv = 0;
    end else begin
      exp_rv = 0;
      if (cfg_we && cfg_slice < NSL) begin
        automatic int s = cfg_slice;
        case (cfg_field)
          0: begin m_en[s] = cfg_wdata[0]; if (cfg_wdata[1]) begin m_wp[s] = 0; m_rp[s] = 0; m_cnt[s] = 0; end end
          1: m_alm[s] = cfg_wdata[10:0];
          3: begin if (cfg_wdata[1]) m_ovf[s] = 0; if (cfg_wdata[2]) m_udf[s] = 0; end
          4: m_mask[s] = cfg_wdata[2:0];
          6: begin m_rp[s] = cfg_wdata[9:0]; m_cnt[s] = (m_wp[s] - m_rp[s] + m_size[s]) % m_size[s]; end
          7: begin m_base[s] = cfg_wdata[9:0]; m_size[s] = cfg_wdata[26:16];
                   m_wp[s] = 0; m_rp[s] = 0; m_cnt[s] = 0; end
          default: ;
        endcase
      end
      if (pop_valid && pop_slice < NSL) begin
        automatic int s = pop_slice;
        if (m_en[s]) begin
          if (m_cnt[s] > 0) begin
            exp_rv = 1;
            exp_rd = m_mem[(m_base[s] + m_rp[s]) % MD];
            m_rp[s] = (m_rp[s] + 1) % m_size[s];
            m_cnt[s]--;
          end else m_udf[s] = 1;
        end
      end else if (push_valid && push_slice < NSL) begin
        automatic int s = push_slice;
        if (m_en[s]) begin
          if (m_cnt[s] < m_size[s]) begin
            m_mem[(m_base[s] + m_wp[s]) % MD] = push_data;
            m_wp[s] = (m_wp[s] + 1) % m_size[s];
            m_cnt[s]++;
          end else m_ovf[s] = 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NCH-1:0] ei, ed;
      for (int c = 0; c < NCH; c++) begin
        ei[c] = ((m_istat(2*c) & m_mask[2*c]) != 0) || ((m_istat(2*c+1) & m_mask[2*c+1]) != 0);
        ed[c] = (m_en[2*c] && m_alarm(2*c)) || (m_en[2*c+1] && m_alarm(2*c+1));
      end
      chk("R3 rd_valid", 32'(rd_valid), 32'(exp_rv));
      if (exp_rv) chk("R2 rd_data order", rd_data, exp_rd);
      chk("R9 irq_pend", 32'(irq_pend), 32'(ei));
      chk("R9 dma_pend", 32'(dma_pend), 32'(ed));
      chk("R6 push_ready", 32'(push_ready), 32'(!pop_valid));
      chk("R3 pop_ready", 32'(pop_ready), 32'd1);
    end
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic cfg_wr(int s, int f, logic [31:0] d);
    cfg_we = 1; cfg_slice = 5'(s); cfg_field = 3'(f); cfg_wdata = d; step(); cfg_we = 0;
  endtask
  task automatic push(int s, logic [31:0] d);
    push_valid = 1; push_slice = 5'(s); push_data = d; step(); push_valid = 0;
  endtask
  task automatic pop(int s);
    pop_valid = 1; pop_slice = 5'(s); step(); pop_valid = 0;
  endtask
  task automatic rd(int s, int f, string tag);
    cfg_slice = 5'(s); cfg_field = 3'(f); #3; chk(tag, cfg_rdata, m_read(s, f));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd(0, 7, "R1 size after reset");
    rd(5, 5, "R1 count after reset");
    rd(23, 0, "R1 ctrl after reset");
    chk("R1 irq_pend zero", 32'(irq_pend), 32'd0);
    chk("R1 dma_pend zero", 32'(dma_pend), 32'd0);

    // R10 disabled slice ignores traffic
    push(2, 32'h1111); pop(2);
    rd(2, 3, "R10 no flags on disabled");
    rd(2, 5, "R10 count on disabled");

    // R12/R2 slice 0 crossing top of memory
    cfg_wr(0, 7, (32'd8 << 16) | 32'd1020);
    rd(0, 7, "R12 size readback");
    cfg_wr(0, 1, 32'd2);
    cfg_wr(0, 4, 32'd3);
    cfg_wr(0, 0, 32'd1);
    rd(0, 2, "R7 tx alarm when empty");
    for (int i = 0; i < 9; i++) push(0, 32'hA000 + 32'(i));
    rd(0, 5, "R3 count full");
    rd(0, 3, "R4 overflow flag");
    rd(0, 2, "R7 tx full no alarm");
    for (int i = 0; i < 3; i++) pop(0);
    for (int i = 0; i < 3; i++) push(0, 32'hB000 + 32'(i));
    rd(0, 6, "R11 pointer readback after wrap");
    for (int i = 0; i < 8; i++) pop(0);
    pop(0);
    rd(0, 3, "R5 underflow flag");
    cfg_wr(0, 3, 32'h6);
    rd(0, 3, "R8 w1c clears flags");

    // R6 same-cycle push and pop
    push(0, 32'hC001);
    push_valid = 1; push_slice = 0; push_data = 32'hDEAD;
    pop_valid = 1; pop_slice = 0; step();
    push_valid = 0; pop_valid = 0; step();
    rd(0, 5, "R6 push blocked by pop");

    // R7 receive slice alarm
    cfg_wr(1, 7, (32'd4 << 16) | 32'd100);
    cfg_wr(1, 1, 32'd3);
    cfg_wr(1, 0, 32'd1);
    for (int i = 0; i < 3; i++) push(1, 32'h5500 + 32'(i));
    rd(1, 2, "R7 rx alarm at level");
    pop(1);
    rd(1, 2, "R7 rx alarm below level");

    // R8/R9 channel 11 receive slice overflow interrupt
    cfg_wr(23, 7, (32'd2 << 16) | 32'd500);
    cfg_wr(23, 1, 32'd100);
    cfg_wr(23, 4, 32'd2);
    cfg_wr(23, 0, 32'd1);
    for (int i = 0; i < 3; i++) push(23, 32'h7700 + 32'(i));
    chk("R9 irq_pend ch11", 32'(irq_pend[11]), 32'd1);
    cfg_wr(23, 3, 32'h2);
    chk("R8 irq cleared", 32'(irq_pend[11]), 32'd0);

    // R11 rewind replays words
    cfg_wr(4, 7, (32'd4 << 16) | 32'd200);
    cfg_wr(4, 0, 32'd1);
    for (int i = 0; i < 3; i++) push(4, 32'h4400 + 32'(i));
    for (int i = 0; i < 3; i++) pop(4);
    cfg_wr(4, 6, 32'd0);
    rd(4, 5, "R11 count after rewind");
    for (int i = 0; i < 3; i++) pop(4);

    // R10 reset command clears pointers and count
    push(4, 32'h9);
    cfg_wr(4, 0, 32'd3);
    rd(4, 6, "R10 reset cmd pointers");
    rd(4, 5, "R10 reset cmd count");

    // interleaved traffic across slices
    for (int i = 0; i < 4; i++) begin
      push(1, 32'h6600 + 32'(i));
      push(4, 32'h6700 + 32'(i));
      pop(1); pop(4);
    end
    step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule